// File: doc/BRIEF.md
# Indirect Extended-Register Access Bridge

This block decodes the register side of a PHY management port. A host issues single-cycle accesses to a 5-bit register address. Addresses 0x00 to 0x1F reach a small direct register bank. Two direct addresses work as a gateway to four larger extended register spaces: a selector register and an address/data window.

The selector register picks one of the four supported spaces with a 5-bit space code and sets one of four access functions. When the function is "address", a write to the window loads that space's own address latch. When it is one of the three "data" functions, a window access reads or writes the extended register that the latch points at. The latch then stays where it is, steps after every access, or steps after writes only.

Each space has its own valid address window. Behavioural word storage stands in for each space. Unsupported space codes and addresses outside a window are dropped without any effect on state.

Top module: `xbr_bridge`

## Requirements
- R1: After reset the selector register, all four address latches, the direct bank and all extended storage read as 0x0000.
- R2: A write to any direct address other than 0x0D and 0x0E stores the 16-bit value, and a later read of that address returns it.
- R3: Space codes 5'h1F, 5'h01, 5'h03 and 5'h07 are the only ones accepted. Their highest valid addresses are 0x0EFD, 0x0904, 0x090D and 0x0200. The latch holds the register number with its space-identifying top nibble removed, so that number must not be written into the latch.
- R4: With selector bits [15:14] = 00, a write to 0x0E loads the selected space's address latch, and a read of 0x0E returns that latch.
- R5: With selector bits [15:14] = 01, a read or write of 0x0E accesses the addressed extended register, and the latch does not change.
- R6: With selector bits [15:14] = 10, the latch increments by one after every accepted read or write of 0x0E.
- R7: With selector bits [15:14] = 11, the latch increments by one after every accepted write of 0x0E, and it does not change after a read.
- R8: A window access with an unsupported space code, or in a data function with the latch beyond the space's window, is ignored on write and returns 0x0000 on read. No storage or latch changes.
- R9: Every supported space keeps its own address latch. Changing the selected space leaves the other latches untouched.
- R10: The selector at 0x0D keeps bits [15:14] (function) and [4:0] (space code). Bits [13:5] always read zero, and only a write to 0x0D changes it.
- R11: A read strobe without a write strobe puts the result on rd_data, with rd_valid high, one clock later. When both strobes are high the write is performed and no read result appears.
- R12: Each space stores BANK_DEPTH words indexed by the low log2(BANK_DEPTH) latch bits, so two in-window addresses that differ by a multiple of BANK_DEPTH share a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Direct register address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read result, registered |
| rd_valid | output | 1 | High for one cycle when rd_data carries a new result |

## Verification
The hardest cases to reach are auto-increment accesses that walk a latch up to the edge of its window and past it. These must stop stepping and stop storing, and the other spaces' latches must keep their values throughout. The stimulus reaches them only through sequences of selector and window writes. It loads a latch just below a boundary in address function, changes to an incrementing function, and keeps accessing until it goes past the boundary. It then returns to address function under a different space code and reads every latch back. A bench model derived from the requirements predicts each read result and feeds it to a scoreboard queue.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
  localparam int XW     = 16;
  localparam int RAW    = 5;
  localparam int NSPACE = 4;

  typedef enum logic [1:0] {
    FN_ADDR   = 2'b00,
    FN_DATA   = 2'b01,
    FN_INC_RW = 2'b10,
    FN_INC_WR = 2'b11
  } xfn_e;

  typedef struct packed {
    logic       ok;
    logic [1:0] idx;
  } space_sel_t;

  // map a space code onto a storage slot
  function automatic space_sel_t space_lookup(input logic [4:0] code);
    space_sel_t s;
    s.ok  = 1'b1;
    s.idx = 2'd0;
    case (code)
      5'h1F:   s.idx = 2'd0;
      5'h01:   s.idx = 2'd1;
      5'h03:   s.idx = 2'd2;
      5'h07:   s.idx = 2'd3;
      default: s.ok  = 1'b0;
    endcase
    return s;
  endfunction

  // highest valid latch value per slot
  function automatic logic [XW-1:0] space_limit(input logic [1:0] idx);
    logic [XW-1:0] lim;
    case (idx)
      2'd0:    lim = 16'h0EFD;
      2'd1:    lim = 16'h0904;
      2'd2:    lim = 16'h090D;
      default: lim = 16'h0200;
    endcase
    return lim;
  endfunction

  function automatic logic addr_in_window(input logic [1:0] idx, input logic [XW-1:0] a);
    return a <= space_limit(idx);
  endfunction

  function automatic logic [XW-1:0] addr_step(input logic [XW-1:0] a);
    return a + 16'd1;
  endfunction

  function automatic logic step_wanted(input xfn_e fn, input logic is_wr);
    return (fn == FN_INC_RW) || (fn == FN_INC_WR && is_wr);
  endfunction
endpackage

// File: rtl/xbr_direct_bank.sv
module xbr_direct_bank #(
  parameter int N  = 32,
  parameter int W  = 16,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/xbr_addr_latch.sv
module xbr_addr_latch
  import xbr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          incr,
  input  logic [XW-1:0] ldata,
  output logic [XW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= ldata;
    else if (incr) q <= addr_step(q);
  end
endmodule

// File: rtl/xbr_mmd_bank.sv
module xbr_mmd_bank #(
  parameter int DEPTH = 64,
  parameter int W     = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/xbr_bridge.sv
module xbr_bridge
  import xbr_pkg::*;
#(
  parameter int             BANK_DEPTH = 64,
  parameter logic [RAW-1:0] CTRL_ADDR  = 5'h0D,
  parameter logic [RAW-1:0] ADAT_ADDR  = 5'h0E
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] reg_addr,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [XW-1:0]  wr_data,
  output logic [XW-1:0]  rd_data,
  output logic           rd_valid
);
  localparam int BAW    = $clog2(BANK_DEPTH);
  localparam int NDIRECT = 1 << RAW;

  // selector state
  xfn_e       func_q;
  logic [4:0] devad_q;
  logic [XW-1:0] ctrl_word;

  // decode
  logic wr_go, rd_go, hit_ctrl, hit_adat, data_mode;
  space_sel_t sp;
  logic [NSPACE-1:0][XW-1:0] lat_vec;
  logic [NSPACE-1:0][XW-1:0] bank_rd;
  logic [XW-1:0] sel_addr;
  logic          in_win;

  // named events
  logic                xacc_ok;
  logic                xacc_drop;
  logic                addr_load;
  logic                incr_pulse;
  logic [NSPACE-1:0]   mmd_we;
  logic                direct_we;
  logic [XW-1:0]       direct_rd;
  logic [XW-1:0]       rd_next;

  assign wr_go     = wr_en;
  assign rd_go     = rd_en & ~wr_en;
  assign hit_ctrl  = (reg_addr == CTRL_ADDR);
  assign hit_adat  = (reg_addr == ADAT_ADDR);
  assign data_mode = (func_q != FN_ADDR);
  assign sp        = space_lookup(devad_q);
  assign sel_addr  = sp.ok ? lat_vec[sp.idx] : '0;
  assign in_win    = sp.ok && addr_in_window(sp.idx, sel_addr);
  assign ctrl_word = {func_q, 9'd0, devad_q};

  assign xacc_ok    = hit_adat && data_mode && in_win && (wr_go || rd_go);
  assign xacc_drop  = hit_adat && (wr_go || rd_go) && (data_mode ? !in_win : !sp.ok);
  assign addr_load  = hit_adat && wr_go && !data_mode && sp.ok;
  assign incr_pulse = xacc_ok && step_wanted(func_q, wr_go);
  assign direct_we  = wr_go && !hit_ctrl && !hit_adat;

  // selector register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      func_q  <= FN_ADDR;
      devad_q <= '0;
    end else if (wr_go && hit_ctrl) begin
      func_q  <= xfn_e'(wr_data[15:14]);
      devad_q <= wr_data[4:0];
    end
  end

  xbr_direct_bank #(.N(NDIRECT), .W(XW)) u_direct (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (direct_we),
    .waddr (reg_addr),
    .wdata (wr_data),
    .raddr (reg_addr),
    .rdata (direct_rd)
  );

  // one latch and one storage bank per supported space
  for (genvar g = 0; g < NSPACE; g++) begin : g_space
    logic mine;
    assign mine      = sp.ok && (sp.idx == 2'(g));
    assign mmd_we[g] = xacc_ok && wr_go && mine;

    xbr_addr_latch u_lat (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (addr_load && mine),
      .incr  (incr_pulse && mine),
      .ldata (wr_data),
      .q     (lat_vec[g])
    );

    xbr_mmd_bank #(.DEPTH(BANK_DEPTH), .W(XW)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mmd_we[g]),
      .addr  (lat_vec[g][BAW-1:0]),
      .wdata (wr_data),
      .rdata (bank_rd[g])
    );
  end

  // read mux
  always_comb begin
    if (hit_ctrl)        rd_next = ctrl_word;
    else if (hit_adat) begin
      if (!data_mode)    rd_next = sel_addr;
      else if (in_win)   rd_next = bank_rd[sp.idx];
      else               rd_next = '0;
    end else             rd_next = direct_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/xbr_bridge_chk.sv
module xbr_bridge_chk #(
  parameter logic [4:0] CTRL_ADDR = 5'h0D
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  reg_addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [15:0] rd_data,
  input logic        rd_valid,
  input logic [1:0]  func_q,
  input logic [15:0] ctrl_word,
  input logic [15:0] sel_addr,
  input logic        xacc_drop,
  input logic        incr_pulse,
  input logic [3:0]  mmd_we
);
  assert_rd_lat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> rd_valid);
  assert_wr_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rd_valid);
  assert_drop_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && xacc_drop) |=> (rd_data == 16'h0000));
  assert_drop_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xacc_drop |-> (mmd_we == 4'b0000));
  assert_drop_noincr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xacc_drop |-> !incr_pulse);
  assert_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mmd_we));
  assert_fixed_noincr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (func_q == 2'b01) |-> !incr_pulse);
  assert_incr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    incr_pulse |=> (sel_addr == $past(sel_addr) + 16'd1));
  assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || reg_addr != CTRL_ADDR) |=> $stable(ctrl_word));
  assert_ctrl_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[13:5] == 9'd0);
endmodule

bind xbr_bridge xbr_bridge_chk #(.CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .func_q     (func_q),
  .ctrl_word  (ctrl_word),
  .sel_addr   (sel_addr),
  .xacc_drop  (xacc_drop),
  .incr_pulse (incr_pulse),
  .mmd_we     (mmd_we)
);

// File: tb/tb_xbr_bridge.sv
`timescale 1ns/1ps
module tb_xbr_bridge;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xbr_bridge #(.BANK_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // bench model, built from the requirements
  logic [1:0]  m_fn = 2'b00;
  logic [4:0]  m_dv = 5'h00;
  logic [15:0] m_dir [int];
  logic [15:0] m_lat [int];
  logic [15:0] m_mem [int];

  logic [15:0] exp_q [$];
  string       tag_q [$];

  // -1 when the code is not accepted, else highest valid address (R3)
  function automatic int m_top(logic [4:0] dv);
    if (dv == 5'h01) return 'h0904;
    if (dv == 5'h03) return 'h090D;
    if (dv == 5'h07) return 'h0200;
    if (dv == 5'h1F) return 'h0EFD;
    return -1;
  endfunction

  function automatic logic [15:0] get_lat(logic [4:0] dv);
    return m_lat.exists(int'(dv)) ? m_lat[int'(dv)] : 16'h0;
  endfunction

  function automatic int m_key(logic [4:0] dv, logic [15:0] a);
    return int'(dv) * 65536 + (int'(a) % DEPTH);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    int lim;
    logic [15:0] la;
    if (a == 5'h0D) begin
      m_fn = d[15:14]; m_dv = d[4:0];
    end else if (a == 5'h0E) begin
      lim = m_top(m_dv);
      la  = get_lat(m_dv);
      if (m_fn == 2'b00) begin
        if (lim >= 0) m_lat[int'(m_dv)] = d;
      end else if (lim >= 0 && int'(la) <= lim) begin
        m_mem[m_key(m_dv, la)] = d;
        if (m_fn != 2'b01) m_lat[int'(m_dv)] = la + 16'd1;
      end
    end else begin
      m_dir[int'(a)] = d;
    end
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, string tag);
    int lim;
    logic [15:0] la, e;
    int k;
    e = 16'h0;
    if (a == 5'h0D) begin
      e = {m_fn, 9'd0, m_dv};
    end else if (a == 5'h0E) begin
      lim = m_top(m_dv);
      la  = get_lat(m_dv);
      if (m_fn == 2'b00) begin
        if (lim >= 0) e = la;
      end else if (lim >= 0 && int'(la) <= lim) begin
        k = m_key(m_dv, la);
        e = m_mem.exists(k) ? m_mem[k] : 16'h0;
        if (m_fn == 2'b10) m_lat[int'(m_dv)] = la + 16'd1;
      end
    end else begin
      e = m_dir.exists(int'(a)) ? m_dir[int'(a)] : 16'h0;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_addr = a; rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected result actual=%h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(5'h0D, "R1 selector");
    rd(5'h0E, "R1 latch");
    rd(5'h03, "R1 direct");
    wr(5'h0D, 16'h4007);
    rd(5'h0E, "R1 storage");

    // R2 direct bank
    wr(5'h05, 16'hA5A5);
    wr(5'h1F, 16'h1234);
    wr(5'h00, 16'hFFFF);
    rd(5'h05, "R2 addr05");
    rd(5'h1F, "R2 addr1F");
    rd(5'h00, "R2 addr00");

    // R10 selector masking
    wr(5'h0D, 16'hFFFF);
    rd(5'h0D, "R10 mask");
    rd(5'h05, "R10 direct unaffected");

    // R4 address load and readback
    wr(5'h0D, 16'h0001);
    wr(5'h0E, 16'h0904);
    rd(5'h0E, "R4 latch dev1");

    // R5 fixed data access
    wr(5'h0D, 16'h4001);
    wr(5'h0E, 16'hBEEF);
    rd(5'h0E, "R5 read1");
    rd(5'h0E, "R5 read2");
    wr(5'h0D, 16'h0001);
    rd(5'h0E, "R5 latch unchanged");

    // R3/R8 published number with nibble is out of window
    wr(5'h0E, 16'h1904);
    wr(5'h0D, 16'h8001);
    wr(5'h0E, 16'h7777);
    rd(5'h0E, "R8 out of window read");
    wr(5'h0D, 16'h0001);
    rd(5'h0E, "R8 no increment");

    // R6 increment on reads and writes, dev3
    wr(5'h0D, 16'h0003);
    wr(5'h0E, 16'h0010);
    wr(5'h0D, 16'h8003);
    wr(5'h0E, 16'h1111);
    wr(5'h0E, 16'h2222);
    wr(5'h0E, 16'h3333);
    wr(5'h0D, 16'h0003);
    rd(5'h0E, "R6 latch after writes");
    wr(5'h0E, 16'h0010);
    wr(5'h0D, 16'h8003);
    rd(5'h0E, "R6 word0");
    rd(5'h0E, "R6 word1");
    rd(5'h0E, "R6 word2");
    wr(5'h0D, 16'h0003);
    rd(5'h0E, "R6 latch after reads");

    // R6/R3 walk across dev3 window edge
    wr(5'h0E, 16'h090C);
    wr(5'h0D, 16'h8003);
    wr(5'h0E, 16'hAAAA);
    wr(5'h0E, 16'hBBBB);
    wr(5'h0E, 16'hCCCC);
    wr(5'h0D, 16'h0003);
    rd(5'h0E, "R3 dev3 stops at edge");

    // R7 increment only on writes, dev7
    wr(5'h0D, 16'h0007);
    wr(5'h0E, 16'h0100);
    wr(5'h0D, 16'hC007);
    wr(5'h0E, 16'h5A5A);
    wr(5'h0E, 16'h6B6B);
    rd(5'h0E, "R7 read no step");
    rd(5'h0E, "R7 read again");
    wr(5'h0D, 16'h0007);
    rd(5'h0E, "R7 latch");

    // R12 folding: 0x0000 and 0x0040 share a word
    wr(5'h0E, 16'h0000);
    wr(5'h0D, 16'h4007);
    wr(5'h0E, 16'h0F0F);
    wr(5'h0D, 16'h0007);
    wr(5'h0E, 16'h0040);
    wr(5'h0D, 16'h4007);
    rd(5'h0E, "R12 alias");

    // R3 vendor space edge
    wr(5'h0D, 16'h001F);
    wr(5'h0E, 16'h0EFD);
    wr(5'h0D, 16'h401F);
    wr(5'h0E, 16'hCAFE);
    rd(5'h0E, "R3 vendor last");
    wr(5'h0D, 16'h001F);
    wr(5'h0E, 16'h0EFE);
    wr(5'h0D, 16'h401F);
    wr(5'h0E, 16'hDEAD);
    rd(5'h0E, "R3 vendor beyond");

    // R8 unsupported code
    wr(5'h0D, 16'h0002);
    wr(5'h0E, 16'h0044);
    rd(5'h0E, "R8 unsupported latch");
    wr(5'h0D, 16'h8002);
    wr(5'h0E, 16'h9999);
    rd(5'h0E, "R8 unsupported data");

    // R9 latches kept per space
    wr(5'h0D, 16'h0001);
    rd(5'h0E, "R9 dev1 latch");
    wr(5'h0D, 16'h0003);
    rd(5'h0E, "R9 dev3 latch");
    wr(5'h0D, 16'h001F);
    rd(5'h0E, "R9 vendor latch");

    // R11 write wins on both strobes
    @(negedge clk);
    reg_addr = 5'h07; wr_data = 16'h4242; wr_en = 1'b1; rd_en = 1'b1;
    m_dir[7] = 16'h4242;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R11 no result on both", {15'd0, rd_valid}, 16'h0);
    rd(5'h07, "R11 write taken");

    repeat (3) @(negedge clk);
    check("R11 queue drained", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule